// File: doc/BRIEF.md
# Digital Audio Receiver Status Registers

This block gathers the per-frame status produced by the front end of a biphase-coded digital audio receiver and presents it as two 8-bit read-only status registers, stat1 (address 03h) and stat2 (address 04h). Level inputs are registered once per clock:

- lock state
- validity
- CRC result
- non-PCM detect
- decoded channel-status fields: audio/non-audio, pre-emphasis, 2-bit rate code and high-rate flag

Parity, biphase and frame-length error strobes are gathered over each frame interval. Each fs tick publishes them.

A status-change flag compares the six channel-status bits of stat1 at every fs tick. A read of stat1 clears it. It stays quiet until the first channel-status block after reset has ended. A channel-status-updating indicator covers the first 32 frames of each block. An aggregated error output merges the unlock state, the frame errors and the status-change flag through two mask inputs. The host bus logic decodes the read strobe for stat1 and drives `rd_stat1_i`.

Top module: `aud_rx_stat_regs`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first stimulus, `stat1_o`, `stat2_o` and `err_o` are all 0.
- R2: `stat1_o` bit mapping, in the order given:
  - bit 7: the error output
  - bit 6: always 0
  - bit 5: `cs_nonaudio_i`
  - bit 4: `nonpcm_i`
  - bit 3: `cs_preemph_i`
  - bits 2:1: `cs_rate_i`
  - bit 0: `cs_hirate_i`

  The field bits follow their inputs one clock later.
- R3: `stat2_o` bit mapping, in the order given:
  - bit 7: channel-status updating
  - bit 6: status change
  - bit 5: CRC error
  - bit 4: unlock
  - bit 3: validity
  - bit 2: frame-length error
  - bit 1: biphase error
  - bit 0: parity error

  CRC, unlock and validity follow `crc_err_i`, `unlock_i` and `valid_i` one clock later.
- R4: Each frame-error bit (parity, biphase, frame-length) rises in the clock after an fs tick when its strobe pulsed at any time since the previous tick, including the tick cycle itself. Otherwise that tick clears it. The parity bit does not depend on `mask_par_i`.
- R5: The status-change bit sets in the clock after an fs tick when stat1 bits 5:0 differ from their value at the previous fs tick. An fs tick with no difference leaves it unchanged.
- R6: The status-change bit clears in the clock after `rd_stat1_i` is high. When a change is detected in the same cycle as the read, the bit is set.
- R7: After reset, no status change is flagged until the first fs tick whose frame index is FRAMES_PER_BLOCK-1 (191) has passed. Comparisons start at the following tick.
- R8: The channel-status-updating bit rises in the clock after an fs tick with frame index 0. It falls in the clock after an fs tick with frame index CS_FRAMES (32), so it is high during frames 0 to 31.
- R9: `err_o` and stat1 bit 7 are the OR of three terms, combined from the register contents with no extra delay:
  - the unlock bit
  - `mask_par_i` AND (parity OR biphase OR frame-length bit)
  - `mask_stc_i` AND the status-change bit
- R10: With `mask_par_i` and `mask_stc_i` both 0, `err_o` follows only the unlock bit, whatever the frame-error and status-change bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fs_tick_i | input | 1 | One-cycle pulse per audio frame |
| frame_idx_i | input | 8 | Frame index within the block, valid with fs_tick_i |
| unlock_i | input | 1 | Clock recovery not locked |
| par_err_i | input | 1 | Parity error strobe |
| bip_err_i | input | 1 | Biphase error strobe |
| frm_err_i | input | 1 | Frame-length error strobe |
| valid_i | input | 1 | Validity bit (1 = not valid) |
| crc_err_i | input | 1 | Channel-status CRC error on either channel |
| nonpcm_i | input | 1 | Non-PCM stream detected |
| cs_nonaudio_i | input | 1 | Channel-status non-audio flag |
| cs_preemph_i | input | 1 | Channel-status pre-emphasis flag |
| cs_rate_i | input | 2 | Channel-status sample-rate code |
| cs_hirate_i | input | 1 | 1 when the recovered rate is 88.2 kHz or more, 0 when 54 kHz or less |
| mask_par_i | input | 1 | Lets frame errors reach the error output |
| mask_stc_i | input | 1 | Lets status change reach the error output |
| rd_stat1_i | input | 1 | Read strobe for stat1 |
| stat1_o | output | 8 | Status register at 03h |
| stat2_o | output | 8 | Status register at 04h |
| err_o | output | 1 | Aggregated error output |

## Verification
Level inputs appear in the registers one clock after they are driven. Frame errors, status change and the updating indicator appear one clock after the fs tick or read that produces them. The error output follows its register terms and the masks within the same cycle. The bench drives every input on the falling edge. Before an fs tick it leaves one idle cycle so that the registered field values are in place, and it samples on the falling edge that follows the single rising edge expected to produce each result.

// File: rtl/aud_stat_pkg.sv
package aud_stat_pkg;
  // Order matches stat1 bits 5:0.
  typedef struct packed {
    logic       nonaudio;
    logic       nonpcm;
    logic       preemph;
    logic [1:0] rate;
    logic       hirate;
  } cs_fields_t;

  localparam int unsigned NUM_FERR = 3;
  localparam int unsigned FERR_PAR = 0;
  localparam int unsigned FERR_BIP = 1;
  localparam int unsigned FERR_FRM = 2;
endpackage

// File: rtl/aud_ferr_capture.sv
module aud_ferr_capture #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [N-1:0] strobe_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] acc_q;
  logic [N-1:0] rep_q;

  for (genvar g = 0; g < N; g++) begin : g_err
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[g] <= 1'b0;
        rep_q[g] <= 1'b0;
      end else if (tick_i) begin
        rep_q[g] <= acc_q[g] | strobe_i[g];
        acc_q[g] <= 1'b0;
      end else if (strobe_i[g]) begin
        acc_q[g] <= 1'b1;
      end
    end

    assert_ferr_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && strobe_i[g]) |=> flag_o[g]);
    assert_ferr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(flag_o[g]));
  end

  assign flag_o = rep_q;
endmodule

// File: rtl/aud_stc_tracker.sv
module aud_stc_tracker
  import aud_stat_pkg::*;
#(
  parameter int unsigned FIDX_W     = 8,
  parameter int unsigned LAST_FRAME = 191
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [FIDX_W-1:0] frame_i,
  input  cs_fields_t        cur_i,
  input  logic              rd_i,
  output logic              stc_o
);
  localparam logic [FIDX_W-1:0] LastIdx = FIDX_W'(LAST_FRAME);

  cs_fields_t snap_q;
  logic       armed_q;
  logic       stc_q;
  logic       change;

  assign change = tick_i && armed_q && (cur_i != snap_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      armed_q <= 1'b0;
      stc_q   <= 1'b0;
    end else begin
      if (tick_i) snap_q <= cur_i;
      if (tick_i && frame_i == LastIdx) armed_q <= 1'b1;
      if (change)    stc_q <= 1'b1;  // set wins over read
      else if (rd_i) stc_q <= 1'b0;
    end
  end

  assign stc_o = stc_q;

  assert_stc_rd_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !change) |=> !stc_o);
  assert_stc_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && change) |=> stc_o);
  assert_stc_quiet_first_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> !stc_o);
  assert_stc_no_tick_no_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !stc_o) |=> !stc_o);
endmodule

// File: rtl/aud_cv_window.sv
module aud_cv_window #(
  parameter int unsigned FIDX_W    = 8,
  parameter int unsigned CS_FRAMES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [FIDX_W-1:0] frame_i,
  output logic              cv_o
);
  localparam logic [FIDX_W-1:0] EndIdx = FIDX_W'(CS_FRAMES);

  logic cv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cv_q <= 1'b0;
    else if (tick_i && frame_i == '0)     cv_q <= 1'b1;
    else if (tick_i && frame_i == EndIdx) cv_q <= 1'b0;
  end

  assign cv_o = cv_q;

  assert_cv_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && frame_i == '0) |=> cv_o);
  assert_cv_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && frame_i == EndIdx) |=> !cv_o);
endmodule

// File: rtl/aud_rx_stat_regs.sv
module aud_rx_stat_regs
  import aud_stat_pkg::*;
#(
  parameter int unsigned FRAMES_PER_BLOCK = 192,
  parameter int unsigned CS_FRAMES        = 32,
  parameter int unsigned FIDX_W           = $clog2(FRAMES_PER_BLOCK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_tick_i,
  input  logic [FIDX_W-1:0] frame_idx_i,
  input  logic              unlock_i,
  input  logic              par_err_i,
  input  logic              bip_err_i,
  input  logic              frm_err_i,
  input  logic              valid_i,
  input  logic              crc_err_i,
  input  logic              nonpcm_i,
  input  logic              cs_nonaudio_i,
  input  logic              cs_preemph_i,
  input  logic [1:0]        cs_rate_i,
  input  logic              cs_hirate_i,
  input  logic              mask_par_i,
  input  logic              mask_stc_i,
  input  logic              rd_stat1_i,
  output logic [7:0]        stat1_o,
  output logic [7:0]        stat2_o,
  output logic              err_o
);
  localparam int unsigned LastFrame = FRAMES_PER_BLOCK - 1;

  cs_fields_t          fields_q;
  logic                unlock_q, valid_q, crc_q;
  logic [NUM_FERR-1:0] ferr_strobe, ferr_flag;
  logic                stc, cv, erf;
  logic                past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fields_q  <= '0;
      unlock_q  <= 1'b0;
      valid_q   <= 1'b0;
      crc_q     <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      fields_q  <= '{nonaudio: cs_nonaudio_i, nonpcm: nonpcm_i, preemph: cs_preemph_i,
                     rate: cs_rate_i, hirate: cs_hirate_i};
      unlock_q  <= unlock_i;
      valid_q   <= valid_i;
      crc_q     <= crc_err_i;
      past_ok_q <= 1'b1;
    end
  end

  always_comb begin
    ferr_strobe           = '0;
    ferr_strobe[FERR_PAR] = par_err_i;
    ferr_strobe[FERR_BIP] = bip_err_i;
    ferr_strobe[FERR_FRM] = frm_err_i;
  end

  aud_ferr_capture #(.N(NUM_FERR)) u_ferr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (fs_tick_i),
    .strobe_i (ferr_strobe),
    .flag_o   (ferr_flag)
  );

  aud_stc_tracker #(.FIDX_W(FIDX_W), .LAST_FRAME(LastFrame)) u_stc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (fs_tick_i),
    .frame_i (frame_idx_i),
    .cur_i   (fields_q),
    .rd_i    (rd_stat1_i),
    .stc_o   (stc)
  );

  aud_cv_window #(.FIDX_W(FIDX_W), .CS_FRAMES(CS_FRAMES)) u_cv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (fs_tick_i),
    .frame_i (frame_idx_i),
    .cv_o    (cv)
  );

  assign erf = unlock_q | (mask_par_i & (|ferr_flag)) | (mask_stc_i & stc);

  assign stat1_o = {erf, 1'b0, fields_q};
  assign stat2_o = {cv, stc, crc_q, unlock_q, valid_q,
                    ferr_flag[FERR_FRM], ferr_flag[FERR_BIP], ferr_flag[FERR_PAR]};
  assign err_o   = erf;

  assert_unlock_reaches_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(unlock_i)) |-> err_o);
  assert_masked_only_unlock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !mask_par_i && !mask_stc_i && !$past(unlock_i)) |-> !err_o);
  assert_unlock_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> (stat2_o[4] == $past(unlock_i)));
endmodule

// File: tb/sim_aud_rx_stat_regs.sv
`timescale 1ns/1ps
module sim_aud_rx_stat_regs;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fs_tick_i = 1'b0;
  logic [7:0] frame_idx_i = '0;
  logic       unlock_i = 0, par_err_i = 0, bip_err_i = 0, frm_err_i = 0;
  logic       valid_i = 0, crc_err_i = 0, nonpcm_i = 0;
  logic       cs_nonaudio_i = 0, cs_preemph_i = 0, cs_hirate_i = 0;
  logic [1:0] cs_rate_i = '0;
  logic       mask_par_i = 0, mask_stc_i = 0, rd_stat1_i = 0;
  logic [7:0] stat1_o, stat2_o;
  logic       err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  aud_rx_stat_regs u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic tick(input logic [7:0] f);
    fs_tick_i = 1'b1; frame_idx_i = f;
    @(negedge clk_i);
    fs_tick_i = 1'b0;
  endtask

  task automatic rd_pulse();
    rd_stat1_i = 1'b1;
    @(negedge clk_i);
    rd_stat1_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 stat1", stat1_o, 8'h00);
    chk("R1 stat2", stat2_o, 8'h00);
    chk("R1 err", {7'd0, err_o}, 8'h00);
  endtask

  task automatic t_fields();
    cs_nonaudio_i = 1; cs_preemph_i = 1; cs_rate_i = 2'b10; cs_hirate_i = 1;
    idle(1);
    chk("R2 fields", stat1_o, 8'h2D);
    nonpcm_i = 1;
    idle(1);
    chk("R2 nonpcm bit4", stat1_o, 8'h3D);
    valid_i = 1; crc_err_i = 1;
    idle(1);
    chk("R3 crc+valid", stat2_o, 8'h28);
    unlock_i = 1;
    idle(1);
    chk("R3 unlock", stat2_o, 8'h38);
    chk("R9 unlock erf bit", stat1_o, 8'hBD);
    unlock_i = 0; valid_i = 0; crc_err_i = 0;
    idle(1);
    chk("R3 levels cleared", stat2_o, 8'h00);
  endtask

  task automatic t_ferr();
    par_err_i = 1; idle(1); par_err_i = 0;
    idle(2);
    chk("R4 not before tick", stat2_o, 8'h00);
    tick(3);
    chk("R4 parity reported", stat2_o, 8'h01);
    chk("R4 parity ignores mask err", {7'd0, err_o}, 8'h00);
    tick(4);
    chk("R4 cleared on clean tick", stat2_o, 8'h00);
    bip_err_i = 1; tick(5); bip_err_i = 0;
    chk("R4 biphase in tick cycle", stat2_o, 8'h02);
    frm_err_i = 1; idle(1); frm_err_i = 0;
    tick(6);
    chk("R4 frame length", stat2_o, 8'h04);
    tick(7);
  endtask

  task automatic t_arm();
    cs_hirate_i = 0; idle(1);
    tick(8);
    chk("R7 suppressed first block", {7'd0, stat2_o[6]}, 8'h00);
    cs_hirate_i = 1; idle(1);
    tick(191);
    chk("R7 suppressed at last frame", {7'd0, stat2_o[6]}, 8'h00);
  endtask

  task automatic t_stc();
    tick(190);
    chk("R5 no change no flag", {7'd0, stat2_o[6]}, 8'h00);
    cs_rate_i = 2'b01; idle(1);
    tick(0);
    chk("R5 change flagged", {7'd0, stat2_o[6]}, 8'h01);
    chk("R8 cv rise frame 0", {7'd0, stat2_o[7]}, 8'h01);
    idle(2);
    chk("R5 flag held", {7'd0, stat2_o[6]}, 8'h01);
    rd_pulse();
    chk("R6 read clears", {7'd0, stat2_o[6]}, 8'h00);
    tick(1);
    chk("R5 unchanged tick", {7'd0, stat2_o[6]}, 8'h00);
    cs_preemph_i = 0; idle(1);
    rd_stat1_i = 1; tick(2); rd_stat1_i = 0;
    chk("R6 set wins over read", {7'd0, stat2_o[6]}, 8'h01);
    rd_pulse();
    chk("R6 second read clears", {7'd0, stat2_o[6]}, 8'h00);
  endtask

  task automatic t_cv();
    tick(31);
    chk("R8 cv high frame 31", {7'd0, stat2_o[7]}, 8'h01);
    tick(32);
    chk("R8 cv low frame 32", {7'd0, stat2_o[7]}, 8'h00);
  endtask

  task automatic t_erf();
    mask_par_i = 1;
    par_err_i = 1; idle(1); par_err_i = 0;
    tick(33);
    chk("R9 masked parity err", {7'd0, err_o}, 8'h01);
    chk("R9 stat1 bit7", {7'd0, stat1_o[7]}, 8'h01);
    tick(34);
    chk("R9 parity gone", {7'd0, err_o}, 8'h00);
    mask_stc_i = 1;
    cs_nonaudio_i = 0; idle(1);
    tick(35);
    chk("R9 stc err", {7'd0, err_o}, 8'h01);
    mask_stc_i = 0; mask_par_i = 0;
    cs_nonaudio_i = 1; idle(1);
    frm_err_i = 1; tick(36); frm_err_i = 0;
    chk("R10 stc+frm set", stat2_o & 8'h44, 8'h44);
    chk("R10 masks off no err", {7'd0, err_o}, 8'h00);
    unlock_i = 1; idle(1);
    chk("R10 unlock still err", {7'd0, err_o}, 8'h01);
    unlock_i = 0; idle(1);
    chk("R10 unlock released", {7'd0, err_o}, 8'h00);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_ni = 1'b1;
    idle(2);
    t_reset();
    t_fields();
    t_ferr();
    t_arm();
    t_stc();
    t_cv();
    t_erf();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule